// File: doc/BRIEF.md
# Supply-Monitor Power-On Reset Sequencer

This block makes the core reset of a chip from two digital supply-level flags and a slow timebase tick. One flag says the supply is above the upper (release) threshold. The other says the supply is below the lower (re-arm) threshold. The analog comparators and the reference that produce these flags sit outside the block.

On the way up, the core stays in reset until the supply has crossed the upper threshold. A programmable number of timebase ticks must then pass before reset is released. That delay is on the order of 128 ms in silicon and is a parameter here. On the way down, losing the upper threshold puts the core back into reset at once. The sequencer then waits for the supply to fall below the lower threshold before it arms a fresh power-up sequence. The gap between the two thresholds gives hysteresis.

Both flags are resynchronized to the block clock. The current sequencer state is also brought out on a port so it can be observed.

Top module: `por_sequencer`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `state_o` is OFF (code 0) and `core_rst` is 1.
- R2: Each comparator flag passes through two flip-flops before the state machine uses it. A change on `sup_above_hi` or `sup_below_lo` can alter `state_o` no earlier than the third rising clock edge after it.
- R3: In OFF with the supply above the upper threshold, the state becomes WAIT (code 1) and `core_rst` stays 1.
- R4: In WAIT, each cycle with `tick`=1 counts one tick. On the clock edge after the DELAY_TICKS-th counted tick, the state becomes RUN (code 2). Ticks seen in any other state are not counted.
- R5: If the upper-threshold flag drops during WAIT, the state returns to OFF and the tick count clears. A later WAIT needs the full DELAY_TICKS again.
- R6: In RUN, loss of the upper-threshold flag moves the state to BROWNOUT (code 3), and `core_rst` goes back to 1.
- R7: In BROWNOUT, `core_rst` stays 1 until the below-lower flag is seen, which moves the state to OFF. That flag takes priority over the upper-threshold flag.
- R8: In BROWNOUT, if the upper-threshold flag returns without the below-lower flag, the state becomes WAIT and a full delay is timed again.
- R9: `core_rst` is 0 exactly when the state is RUN.
- R10: The internal tick count never exceeds DELAY_TICKS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| sup_above_hi | input | 1 | Supply is above the upper threshold (asynchronous) |
| sup_below_lo | input | 1 | Supply is below the lower threshold (asynchronous) |
| tick | input | 1 | One-cycle timebase pulse |
| core_rst | output | 1 | Active-high reset to the core |
| state_o | output | 2 | Current state: 0 OFF, 1 WAIT, 2 RUN, 3 BROWNOUT |

## Verification
The assertions check the following on every cycle:
- The tick count stays within its bound.
- The count is clear after any cycle spent outside WAIT.
- RUN is entered only from WAIT, and only once the delay is complete.
- Release of reset coincides with the timer having finished.
- RUN falls to BROWNOUT as soon as the synchronized upper flag is lost.

Only the bench scenarios can show the following:
- The exact three-edge latency through the synchronizers.
- That ticks outside WAIT are ignored.
- That an aborted wait really restarts from zero.
- That the lower flag wins in BROWNOUT.

These rely on a random supply profile compared against a cycle model.

// File: rtl/por_pkg.sv
package por_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_WAIT  = 2'd1,
        ST_RUN   = 2'd2,
        ST_BROWN = 2'd3
    } por_state_e;

    typedef struct packed {
        logic above_hi;
        logic below_lo;
    } supply_lvl_t;

    localparam int SYNC_STAGES = 2;

    // Next-state rule of the sequencer.
    function automatic por_state_e por_next(
        input por_state_e  cur,
        input supply_lvl_t lvl,
        input logic        delay_done
    );
        por_state_e nxt;
        nxt = cur;
        unique case (cur)
            ST_OFF:   if (lvl.above_hi) nxt = ST_WAIT;
            ST_WAIT:  begin
                if (!lvl.above_hi)  nxt = ST_OFF;
                else if (delay_done) nxt = ST_RUN;
            end
            ST_RUN:   if (!lvl.above_hi) nxt = ST_BROWN;
            ST_BROWN: begin
                if (lvl.below_lo)      nxt = ST_OFF;
                else if (lvl.above_hi) nxt = ST_WAIT;
            end
            default:  nxt = ST_OFF;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/por_sync.sv
module por_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '0;
            else     chain <= {chain[STAGES-2:0], d_async[b]};
        end
        assign q_sync[b] = chain[STAGES-1];
    end
endmodule

// File: rtl/por_delay_timer.sv
module por_delay_timer #(
    parameter int DELAY_TICKS = 128,
    localparam int CNT_W = $clog2(DELAY_TICKS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_en,
    input  logic             tick,
    output logic             done,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(DELAY_TICKS);

    always_ff @(posedge clk) begin
        if (rst || !run_en)              count <= '0;
        else if (tick && count != LIMIT) count <= count + 1'b1;
    end

    assign done = (count == LIMIT);

    // R10: count is bounded
    assert_count_bound_R10: assert property (@(posedge clk) disable iff (rst)
        count <= LIMIT);

    // R5: count cleared after any cycle outside the waiting state
    assert_count_clear_R5: assert property (@(posedge clk) disable iff (rst)
        !run_en |=> count == '0);
endmodule

// File: rtl/por_fsm.sv
module por_fsm
    import por_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  supply_lvl_t lvl,
    input  logic        delay_done,
    output por_state_e  state
);
    always_ff @(posedge clk) begin
        if (rst) state <= ST_OFF;
        else     state <= por_next(state, lvl, delay_done);
    end

    // R4: RUN is entered only from WAIT with the delay complete
    assert_run_entry_R4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && $past(state) != ST_RUN) |->
            ($past(state) == ST_WAIT && $past(delay_done)));

    // R6: losing the upper flag in RUN leads to BROWNOUT
    assert_brownout_R6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && !lvl.above_hi) |=> state == ST_BROWN);

    // R3: OFF never jumps straight to RUN
    assert_off_exit_R3: assert property (@(posedge clk) disable iff (rst)
        state == ST_OFF |=> state != ST_RUN);
endmodule

// File: rtl/por_sequencer.sv
module por_sequencer
    import por_pkg::*;
#(
    parameter int DELAY_TICKS = 128
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sup_above_hi,
    input  logic       sup_below_lo,
    input  logic       tick,
    output logic       core_rst,
    output logic [1:0] state_o
);
    localparam int CNT_W = $clog2(DELAY_TICKS + 1);

    logic [1:0]       lvl_raw;
    logic [1:0]       lvl_sync;
    supply_lvl_t      lvl;
    por_state_e       state;
    logic             delay_done;
    logic [CNT_W-1:0] delay_count;

    assign lvl_raw = {sup_above_hi, sup_below_lo};

    por_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (lvl_raw),
        .q_sync  (lvl_sync)
    );

    assign lvl.above_hi = lvl_sync[1];
    assign lvl.below_lo = lvl_sync[0];

    por_delay_timer #(.DELAY_TICKS(DELAY_TICKS)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .run_en (state == ST_WAIT),
        .tick   (tick),
        .done   (delay_done),
        .count  (delay_count)
    );

    por_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .lvl        (lvl),
        .delay_done (delay_done),
        .state      (state)
    );

    assign core_rst = (state != ST_RUN);
    assign state_o  = state;

    // R9: reset is released only on an edge where the timer had finished
    assert_release_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(core_rst) |-> $past(delay_done));
endmodule

// File: tb/por_sequencer_tb.sv
module por_sequencer_tb;
    localparam int DLY = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       hi = 1'b0, lo = 1'b1, tk = 1'b0;
    logic       core_rst;
    logic [1:0] state_o;
    int         total = 0, bad = 0;
    bit         finished = 1'b0;

    always #10 clk = ~clk;

    por_sequencer #(.DELAY_TICKS(DLY)) u_dut (
        .clk(clk), .rst(rst), .sup_above_hi(hi), .sup_below_lo(lo),
        .tick(tk), .core_rst(core_rst), .state_o(state_o)
    );

    // cycle model built from the requirements
    logic [1:0] m_hi_p, m_lo_p;
    logic [1:0] m_st;
    int         m_cnt;

    function automatic logic [1:0] exp_next(input logic [1:0] s, input logic h,
                                            input logic l, input bit dn);
        case (s)
            2'd0: return h ? 2'd1 : 2'd0;
            2'd1: return !h ? 2'd0 : (dn ? 2'd2 : 2'd1);
            2'd2: return h ? 2'd2 : 2'd3;
            default: return l ? 2'd0 : (h ? 2'd1 : 2'd3);
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_hi_p <= '0; m_lo_p <= '0; m_st <= 2'd0; m_cnt <= 0;
        end else begin
            m_hi_p <= {m_hi_p[0], hi};
            m_lo_p <= {m_lo_p[0], lo};
            m_st   <= exp_next(m_st, m_hi_p[1], m_lo_p[1], m_cnt == DLY);
            if (m_st != 2'd1)            m_cnt <= 0;
            else if (tk && m_cnt != DLY) m_cnt <= m_cnt + 1;
        end
    end

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); @(negedge clk);
        end
    endtask

    task automatic pulse(input int n);
        for (int i = 0; i < n; i++) begin
            tk = 1'b1; step(); tk = 1'b0; step();
        end
    endtask

    task automatic chk(input string req, input logic [1:0] exp_s);
        total++;
        if (state_o !== exp_s || core_rst !== (exp_s != 2'd2)) begin
            bad++;
            $display("FAIL %s: state=%0d rst=%0b expected state=%0d rst=%0b",
                     req, state_o, core_rst, exp_s, exp_s != 2'd2);
        end
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        @(negedge clk); step(2);
        chk("R1 in reset", 2'd0);
        rst = 1'b0; step();
        chk("R1 after reset", 2'd0);

        pulse(DLY + 2);                  // ticks in OFF must be ignored
        lo = 1'b0; hi = 1'b1; step(2);
        chk("R2 two edges latency", 2'd0);
        step();
        chk("R3 enter wait", 2'd1);
        pulse(DLY - 1);
        chk("R4 still waiting", 2'd1);
        pulse(1);
        chk("R4 release", 2'd2);

        hi = 1'b0; step(2);
        chk("R2 run holds two edges", 2'd2);
        step();
        chk("R6 brownout", 2'd3);
        pulse(DLY + 1);
        chk("R7 brownout holds", 2'd3);

        hi = 1'b1; step(3);
        chk("R8 rewait", 2'd1);
        pulse(2);
        hi = 1'b0; step(3);
        chk("R5 abort to off", 2'd0);
        hi = 1'b1; step(3);
        chk("R5 wait again", 2'd1);
        pulse(DLY - 1);
        chk("R5 count restarted", 2'd1);
        pulse(1);
        chk("R4 release again", 2'd2);

        hi = 1'b0; step(3);
        chk("R6 brownout again", 2'd3);
        hi = 1'b1; lo = 1'b1; step(3);
        chk("R7 lower flag priority", 2'd0);
        hi = 1'b0; step(3);
        chk("R7 off stays", 2'd0);

        // random supply profile compared with the model (R9 each cycle)
        for (int c = 0; c < 4000; c++) begin
            tk = ($urandom % 4) == 0;
            if (($urandom % 30) == 0) begin
                case ($urandom % 3)
                    0: begin hi = 1'b0; lo = 1'b1; end
                    1: begin hi = 1'b0; lo = 1'b0; end
                    default: begin hi = 1'b1; lo = 1'b0; end
                endcase
            end
            step();
            chk("R9 random vs model", m_st);
        end

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule